// File: doc/BRIEF.md
# High-Speed Hub Port Reset Chirp Responder

This block sits beside one downstream port of a high-speed hub and runs the speed handshake during a port reset. A one-cycle reset command starts the sequence. The port drives SE0 and times the whole reset in ticks. While the port drives SE0, the block watches a device chirp K indication and accepts it only after it has held for a set number of ticks. When the device's chirp ends, the block answers with alternating chirp K and chirp J symbols, each one chirp-bit long. It starts a new symbol only while enough of the reset is left for a full symbol plus an SE0 guard interval. Then SE0 finishes the reset.

All timing runs on a tick input, for example one tick per microsecond, so the block needs no fast clock. If no device chirp is accepted, or if the port is marked low-speed, the result is a plain full-speed reset of the same length. When the reset ends, the block raises a high-speed flag only if it sent at least one chirp symbol. The flag stays up until the next reset begins.

Top module: `hub_chirp_resp`

## Requirements
- R1: A `port_reset` pulse while idle starts the reset in the next cycle. The port is then active (exactly one of `drv_se0`, `drv_chirp_k`, `drv_chirp_j` high) for exactly `RESET_TICKS` ticks. After that all three drive outputs are low.
- R2: While `port_is_ls` is high, no device chirp is accepted and no chirp symbol is driven.
- R3: A device chirp K counts only after `dev_chirp_k` has been high on `FILT_TICKS` consecutive ticks. A shorter pulse has no effect.
- R4: Once an accepted device chirp ends, the hub chirp K starts in the cycle after the first cycle in which `dev_chirp_k` is sampled low.
- R5: Hub chirp symbols alternate, starting with K. Each symbol lasts `BIT_TICKS` ticks.
- R6: A symbol starts only if its tick count since the start of the reset is at most `RESET_TICKS - GUARD_TICKS - BIT_TICKS`. Otherwise SE0 is driven until the reset ends.
- R7: `hs_port` is cleared when a reset starts. It is set when that reset ends only if at least one hub chirp K was driven.
- R8: `drv_se0`, `drv_chirp_k` and `drv_chirp_j` are never high together in any pair.
- R9: A `port_reset` pulse during an active reset is ignored. The timeline of that reset is unchanged.
- R10: If no device chirp is accepted, `drv_se0` is held for the whole reset and `hs_port` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_reset | input | 1 | One-cycle request to reset the port |
| port_is_ls | input | 1 | Port carries a low-speed device; chirp is not attempted |
| dev_chirp_k | input | 1 | Device chirp K seen on the line |
| tick | input | 1 | Timebase strobe; all intervals are counted in ticks |
| drv_se0 | output | 1 | Request to drive SE0 |
| drv_chirp_k | output | 1 | Request to drive chirp K |
| drv_chirp_j | output | 1 | Request to drive chirp J |
| hs_port | output | 1 | Port completed the handshake and runs high-speed |

## Verification
The assertions assume two things about the inputs: `port_is_ls` holds steady for the length of a reset, and `tick` is never held off long enough to stretch a symbol beyond the reset window. The bench keeps `tick` high on every cycle and sets `port_is_ls` only between resets. This makes every interval an exact cycle count. It places device chirps, short glitches and extra reset pulses at chosen cycles, including a chirp that ends exactly at the last cycle allowed to start a symbol and one that ends one cycle later.

// File: rtl/hub_chirp_resp.sv
module hub_chirp_resp #(
  parameter int RESET_TICKS = 10000,
  parameter int FILT_TICKS  = 3,
  parameter int BIT_TICKS   = 50,
  parameter int GUARD_TICKS = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic port_reset,
  input  logic port_is_ls,
  input  logic dev_chirp_k,
  input  logic tick,
  output logic drv_se0,
  output logic drv_chirp_k,
  output logic drv_chirp_j,
  output logic hs_port
);
  localparam int CW = $clog2(RESET_TICKS + 1);
  localparam int BW = $clog2(BIT_TICKS + 1);
  localparam int FW = $clog2(FILT_TICKS + 1);
  localparam logic [CW-1:0] T_END  = CW'(RESET_TICKS - 1);
  localparam logic [CW-1:0] T_LAST = CW'(RESET_TICKS - GUARD_TICKS - BIT_TICKS);
  localparam logic [BW-1:0] B_END  = BW'(BIT_TICKS - 1);
  localparam logic [FW-1:0] F_END  = FW'(FILT_TICKS - 1);

  typedef enum logic [2:0] {S_IDLE, S_LISTEN, S_DEVK, S_CHK, S_CHJ, S_TAIL} st_t;

  st_t           st;
  logic [CW-1:0] t0;
  logic [BW-1:0] t2;
  logic [FW-1:0] fc;
  logic          chirped;

  wire [CW-1:0] t0_nxt  = t0 + CW'(tick);
  wire          room    = t0_nxt <= T_LAST;
  wire          end_now = tick && (t0 == T_END);

  assign drv_chirp_k = (st == S_CHK);
  assign drv_chirp_j = (st == S_CHJ);
  assign drv_se0     = (st == S_LISTEN) || (st == S_DEVK) || (st == S_TAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      t0      <= '0;
      t2      <= '0;
      fc      <= '0;
      chirped <= 1'b0;
      hs_port <= 1'b0;
    end else if (st == S_IDLE) begin
      if (port_reset) begin
        st      <= S_LISTEN;
        t0      <= '0;
        fc      <= '0;
        chirped <= 1'b0;
        hs_port <= 1'b0;
      end
    end else begin
      t0 <= t0_nxt;
      if (end_now) begin
        st      <= S_IDLE;
        hs_port <= chirped;
      end else begin
        case (st)
          S_LISTEN:
            if (dev_chirp_k && !port_is_ls) begin
              if (tick) begin
                if (fc == F_END) st <= S_DEVK;
                else             fc <= fc + 1'b1;
              end
            end else begin
              fc <= '0;
            end
          S_DEVK:
            if (!dev_chirp_k) begin
              if (room) begin
                st      <= S_CHK;
                t2      <= '0;
                chirped <= 1'b1;
              end else begin
                st <= S_TAIL;
              end
            end
          S_CHK, S_CHJ:
            if (tick) begin
              if (t2 == B_END) begin
                t2 <= '0;
                if (!room)            st <= S_TAIL;
                else if (st == S_CHK) st <= S_CHJ;
                else                  st <= S_CHK;
              end else begin
                t2 <= t2 + 1'b1;
              end
            end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hub_chirp_resp_chk.sv
module hub_chirp_resp_chk #(
  parameter int RESET_TICKS = 10000,
  parameter int FILT_TICKS  = 3,
  parameter int BIT_TICKS   = 50,
  parameter int GUARD_TICKS = 300
) (
  input logic clk,
  input logic rst_n,
  input logic port_reset,
  input logic port_is_ls,
  input logic dev_chirp_k,
  input logic tick,
  input logic drv_se0,
  input logic drv_chirp_k,
  input logic drv_chirp_j,
  input logic hs_port
);
  localparam int LAST = RESET_TICKS - GUARD_TICKS - BIT_TICKS;

  wire active = drv_se0 | drv_chirp_k | drv_chirp_j;
  int  tcnt, krun, jrun;
  logic saw_k;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= 0; krun <= 0; jrun <= 0; saw_k <= 1'b0;
    end else begin
      tcnt  <= active ? tcnt + int'(tick) : 0;
      krun  <= drv_chirp_k ? krun + int'(tick) : 0;
      jrun  <= drv_chirp_j ? jrun + int'(tick) : 0;
      saw_k <= active ? (saw_k | drv_chirp_k) : 1'b0;
    end
  end

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drv_se0, drv_chirp_k, drv_chirp_j}));

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && port_reset) |=> drv_se0);

  p_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> tcnt == RESET_TICKS);

  p_ls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    port_is_ls |-> !(drv_chirp_k || drv_chirp_j));

  p_kfirst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drv_chirp_j |-> $past(drv_chirp_k || drv_chirp_j));

  p_kbit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_chirp_k) |-> krun == BIT_TICKS);

  p_jbit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_chirp_j) |-> jrun == BIT_TICKS);

  p_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(drv_chirp_k) || $rose(drv_chirp_j)) |-> tcnt <= LAST);

  p_hsset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_port) |-> (saw_k && !active));

  p_hsclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !hs_port);
endmodule

bind hub_chirp_resp hub_chirp_resp_chk #(
  .RESET_TICKS(RESET_TICKS), .FILT_TICKS(FILT_TICKS),
  .BIT_TICKS(BIT_TICKS), .GUARD_TICKS(GUARD_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .port_reset(port_reset), .port_is_ls(port_is_ls),
  .dev_chirp_k(dev_chirp_k), .tick(tick), .drv_se0(drv_se0),
  .drv_chirp_k(drv_chirp_k), .drv_chirp_j(drv_chirp_j), .hs_port(hs_port)
);

// File: tb/hub_chirp_resp_bench.sv
module hub_chirp_resp_bench;
  localparam int RST  = 400;
  localparam int FILT = 4;
  localparam int BIT  = 10;
  localparam int GRD  = 50;
  localparam int LAST = RST - GRD - BIT;
  localparam int SPAN = RST + 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_reset = 1'b0, port_is_ls = 1'b0, dev_chirp_k = 1'b0, tick = 1'b1;
  logic drv_se0, drv_chirp_k, drv_chirp_j, hs_port;

  always #5 clk = ~clk;

  hub_chirp_resp #(.RESET_TICKS(RST), .FILT_TICKS(FILT), .BIT_TICKS(BIT), .GUARD_TICKS(GRD))
  u_hub_chirp_resp (
    .clk(clk), .rst_n(rst_n), .port_reset(port_reset), .port_is_ls(port_is_ls),
    .dev_chirp_k(dev_chirp_k), .tick(tick), .drv_se0(drv_se0),
    .drv_chirp_k(drv_chirp_k), .drv_chirp_j(drv_chirp_j), .hs_port(hs_port)
  );

  typedef struct {
    logic [3:0] exp;
    int         cyc;
    string      tag;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad   = 0;

  function automatic logic [3:0] expect_at(int n, bit ok, int s);
    logic se0, k, j, hs;
    int idx;
    se0 = 1'b0; k = 1'b0; j = 1'b0; hs = 1'b0;
    if (n < RST) begin
      idx = (n >= s) ? (n - s) / BIT : 0;
      if (ok && n >= s && s + idx * BIT <= LAST) begin
        if (idx % 2 == 0) k = 1'b1;
        else              j = 1'b1;
      end else begin
        se0 = 1'b1;
      end
    end else begin
      hs = ok;
    end
    return {se0, k, j, hs};
  endfunction

  // c/len: real device chirp; gc/gl: short glitch; extra: cycle of a stray reset pulse
  task automatic run_reset(input bit ls, input int c, input int len, input int gc,
                           input int gl, input int extra, input string tag);
    bit ok;
    int s;
    s  = c + len + 1;
    ok = !ls && len >= FILT && s <= LAST;
    @(negedge clk);
    port_is_ls = ls;
    port_reset = 1'b1;
    @(posedge clk);
    #1;
    port_reset = 1'b0;
    for (int n = 0; n < SPAN; n++) begin
      item_t it;
      it.exp = expect_at(n, ok, s);
      it.cyc = n;
      it.tag = tag;
      q.push_back(it);
    end
    for (int n = 0; n < SPAN; n++) begin
      @(negedge clk);
      dev_chirp_k = (n >= c && n < c + len) || (n >= gc && n < gc + gl);
      port_reset  = (n == extra);
    end
    dev_chirp_k = 1'b0;
    port_reset  = 1'b0;
  endtask

  always @(negedge clk) begin
    if (q.size() != 0) begin
      item_t it;
      logic [3:0] got;
      it  = q.pop_front();
      got = {drv_se0, drv_chirp_k, drv_chirp_j, hs_port};
      total++;
      if (got !== it.exp) begin
        bad++;
        $display("FAIL %s cycle %0d got={se0,k,j,hs}=%b expected=%b", it.tag, it.cyc, got, it.exp);
      end
    end
  end

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog expired got=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if ({drv_se0, drv_chirp_k, drv_chirp_j, hs_port} !== 4'b0000) begin
      bad++;
      $display("FAIL R1 reset state got=%b expected=0000",
               {drv_se0, drv_chirp_k, drv_chirp_j, hs_port});
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    total++;
    if ({drv_se0, drv_chirp_k, drv_chirp_j, hs_port} !== 4'b0000) begin
      bad++;
      $display("FAIL R1 idle after reset got=%b expected=0000",
               {drv_se0, drv_chirp_k, drv_chirp_j, hs_port});
    end
    run_reset(0, 0,   0,  0,  0,  -1, "R1 R10 plain reset");
    run_reset(0, 20,  30, 0,  0,  -1, "R3 R4 R5 R6 R7 R8 chirp");
    run_reset(1, 20,  30, 0,  0,  -1, "R2 R10 low-speed port");
    run_reset(0, 0,   0,  20, 3,  -1, "R3 R10 glitch only");
    run_reset(0, 50,  40, 10, 3,  -1, "R3 R4 glitch then chirp");
    run_reset(0, 330, 9,  0,  0,  -1, "R6 R7 last start");
    run_reset(0, 331, 9,  0,  0,  -1, "R6 R7 R10 too late");
    run_reset(0, 15,  25, 0,  0,  100, "R9 stray reset pulse");
    run_reset(0, 100, 4,  0,  0,  -1, "R3 R5 minimum filter");
    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule